// File: doc/BRIEF.md
# Integer ALU with Status Flag Word

This block is the single-cycle integer datapath of a small processor. It takes two operands and a three-bit operation select and returns the result combinationally in the same cycle. The second operand may come from a register or from an immediate; that choice is made before the operand reaches the block. It covers addition, subtraction, three bitwise operations and three shift kinds.

The block also holds the processor flag word. The word is as wide as the datapath. Four status bits (carry, overflow, zero, sign) are refreshed from the current operation on a clock edge, but only when the update enable is high. Two control bits (interrupt enable, user mode) sit beside them and ALU operations never change them. Every bit above those six reads as zero. Software can load the whole word in one cycle, for example to restore it after an interrupt. A load in the same cycle as an update takes priority over the update.

Top module: `alu_flags`

## Requirements
- R1: With `op_sel_i` = 0 (add), `result_o` is `op_a_i + op_b_i` modulo 2^32. On an update, flag bit 0 (carry) takes the carry out of bit 31.
- R2: With `op_sel_i` = 1 (subtract), `result_o` is `op_a_i - op_b_i` modulo 2^32. On an update, flag bit 0 is set exactly when `op_a_i < op_b_i` unsigned, which is a borrow.
- R3: On an update, flag bit 1 (overflow) is set on signed overflow of an add or a subtract. For select values 2 to 7, flag bits 0 and 1 are both cleared.
- R4: Select 2 gives `op_a_i ^ op_b_i`, select 3 gives `op_a_i | op_b_i`, and select 4 gives `op_a_i & op_b_i`.
- R5: Select 5 is a logical left shift, select 6 a logical right shift and select 7 an arithmetic right shift (sign fill) of `op_a_i`. The shift amount is only bits 4:0 of `op_b_i`.
- R6: On an update, flag bit 2 (zero) is set when the 32-bit result is all zeros, and flag bit 3 (sign) takes result bit 31.
- R7: The flag word changes only on a rising clock edge with `flag_upd_i` or `flag_load_i` high. Otherwise it holds its value.
- R8: An update leaves flag bit 4 (interrupt enable) and bit 5 (user mode) unchanged.
- R9: When `flag_load_i` is high at a clock edge, flag bits 5:0 take `flag_wdata_i[5:0]`, even if `flag_upd_i` is also high. Flag bits 31:6 always read zero.
- R10: While `rst_ni` is low, the whole flag word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 32 | First operand, and the data to be shifted |
| op_b_i | input | 32 | Second operand, from a register or an immediate; its low bits give the shift amount |
| op_sel_i | input | 3 | Operation select (0 add, 1 sub, 2 xor, 3 or, 4 and, 5 sll, 6 srl, 7 sra) |
| flag_upd_i | input | 1 | Store the status bits of this operation at the clock edge |
| flag_load_i | input | 1 | Load the flag word from `flag_wdata_i` |
| flag_wdata_i | input | 32 | Flag word value for a software load |
| result_o | output | 32 | Operation result, combinational |
| flags_o | output | 32 | Flag word |

## Verification
The bench builds the block with the default `DATA_W` of 32. That width gives a five-bit shift amount, so shift counts of 32 and above wrap, and bit 31 serves as both the carry-out position and the sign position. At this width the wrap of unsigned add, the signed overflow edges around 0x7FFFFFFF and 0x80000000, and sign fill on arithmetic shifts can all be driven with plain literal operands. It also lets the bench check a full-word load of all ones, where the reserved bits must drop to zero.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_XOR = 3'd2,
    OP_OR  = 3'd3,
    OP_AND = 3'd4,
    OP_SLL = 3'd5,
    OP_SRL = 3'd6,
    OP_SRA = 3'd7
  } alu_op_e;

  localparam int unsigned FLG_C    = 0;
  localparam int unsigned FLG_V    = 1;
  localparam int unsigned FLG_Z    = 2;
  localparam int unsigned FLG_N    = 3;
  localparam int unsigned FLG_IE   = 4;
  localparam int unsigned FLG_UM   = 5;
  localparam int unsigned FLG_LIVE = 6;
  localparam int unsigned STAT_W   = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } status_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o = full[W-1:0];
  // subtract reports borrow, the inverse of the raw carry out
  assign carry_o = sub_i ? ~full[W] : full[W];
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned W    = 32,
  parameter int unsigned SH_W = $clog2(W)
) (
  input  logic [W-1:0]    data_i,
  input  logic [SH_W-1:0] amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [W-1:0]    data_o
);
  logic [W-1:0] rev_in, rev_out, pre;
  logic [W-1:0] stg [0:SH_W];
  logic         fill;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = data_i[W-1-i];
    assign rev_out[i] = stg[SH_W][W-1-i];
  end

  // left shift = right shift of the bit-reversed word
  assign pre    = left_i ? rev_in : data_i;
  assign fill   = arith_i & ~left_i & data_i[W-1];
  assign stg[0] = pre;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{STEP{fill}}, stg[s][W-1:STEP]} : stg[s];
  end

  assign data_o = left_i ? rev_out : stg[SH_W];
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flags_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_i,
  input  logic                load_i,
  input  logic [FLG_LIVE-1:0] wdata_i,
  input  status_t             status_i,
  output logic [W-1:0]        flags_o
);
  logic [FLG_LIVE-1:0] live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
    end else if (load_i) begin
      live_q <= wdata_i;
    end else if (upd_i) begin
      live_q[STAT_W-1:0] <= status_i;
    end
  end

  assign flags_o = {{(W-FLG_LIVE){1'b0}}, live_q};
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [2:0]        op_sel_i,
  input  logic              flag_upd_i,
  input  logic              flag_load_i,
  input  logic [DATA_W-1:0] flag_wdata_i,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W-1:0] flags_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  alu_op_e           op;
  logic [DATA_W-1:0] sum, shifted, res;
  logic              carry, ovf, is_arith;
  status_t           status;
  logic              unused_wdata_hi;

  assign op       = alu_op_e'(op_sel_i);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .sub_i  (op == OP_SUB),
    .sum_o  (sum),
    .carry_o(carry),
    .ovf_o  (ovf)
  );

  alu_shift #(.W(DATA_W), .SH_W(SH_W)) u_shift (
    .data_i (op_a_i),
    .amt_i  (op_b_i[SH_W-1:0]),
    .left_i (op == OP_SLL),
    .arith_i(op == OP_SRA),
    .data_o (shifted)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:         res = sum;
      OP_XOR:                 res = op_a_i ^ op_b_i;
      OP_OR:                  res = op_a_i | op_b_i;
      OP_AND:                 res = op_a_i & op_b_i;
      OP_SLL, OP_SRL, OP_SRA: res = shifted;
      default:                res = sum;
    endcase
  end

  assign status.c = is_arith & carry;
  assign status.v = is_arith & ovf;
  assign status.z = (res == '0);
  assign status.n = res[DATA_W-1];

  alu_flag_reg #(.W(DATA_W)) u_flag_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (flag_upd_i),
    .load_i  (flag_load_i),
    .wdata_i (flag_wdata_i[FLG_LIVE-1:0]),
    .status_i(status),
    .flags_o (flags_o)
  );

  assign result_o        = res;
  assign unused_wdata_hi = ^flag_wdata_i[DATA_W-1:FLG_LIVE];
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
  import alu_flags_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] op_a_i,
  input logic [W-1:0] op_b_i,
  input logic [2:0]   op_sel_i,
  input logic         flag_upd_i,
  input logic         flag_load_i,
  input logic [W-1:0] flag_wdata_i,
  input logic [W-1:0] result_o,
  input logic [W-1:0] flags_o
);
  logic alu_upd;
  assign alu_upd = flag_upd_i && !flag_load_i;

  // R10
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> flags_o == '0);

  // R9
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[W-1:FLG_LIVE] == '0);

  // R9
  load_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_load_i |=> flags_o[FLG_LIVE-1:0] == $past(flag_wdata_i[FLG_LIVE-1:0]));

  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_upd_i && !flag_load_i) |=> $stable(flags_o));

  // R8
  ctrl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_upd |=> flags_o[FLG_UM:FLG_IE] == $past(flags_o[FLG_UM:FLG_IE]));

  // R6
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_upd |=> flags_o[FLG_Z] == ($past(result_o) == '0));

  // R6
  sign_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_upd |=> flags_o[FLG_N] == $past(result_o[W-1]));

  // R3
  logic_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_upd && op_sel_i >= 3'd2) |=> flags_o[FLG_V:FLG_C] == 2'b00);

  // R2
  borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_upd && op_sel_i == 3'd1) |=> flags_o[FLG_C] == ($past(op_a_i) < $past(op_b_i)));
endmodule

bind alu_flags alu_flags_chk #(.W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_a_i      (op_a_i),
  .op_b_i      (op_b_i),
  .op_sel_i    (op_sel_i),
  .flag_upd_i  (flag_upd_i),
  .flag_load_i (flag_load_i),
  .flag_wdata_i(flag_wdata_i),
  .result_o    (result_o),
  .flags_o     (flags_o)
);

// File: tb/alu_flags_tb.sv
`timescale 1ns/1ps
module alu_flags_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] op_a, op_b, wdata, result, flags;
  logic [2:0]   op_sel;
  logic         upd, load;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] q_res[$];
  logic [31:0] q_flg[$];
  string       q_tag[$];
  logic [5:0]  model_flg = '0;

  always #2 clk = ~clk;

  alu_flags #(.DATA_W(W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .op_a_i      (op_a),
    .op_b_i      (op_b),
    .op_sel_i    (op_sel),
    .flag_upd_i  (upd),
    .flag_load_i (load),
    .flag_wdata_i(wdata),
    .result_o    (result),
    .flags_o     (flags)
  );

  task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic u, input logic l, input logic [31:0] wd, input string tag);
    logic [32:0] t;
    logic [31:0] r;
    logic        c, v;
    @(negedge clk);
    op_sel = op; op_a = a; op_b = b; upd = u; load = l; wdata = wd;
    c = 1'b0; v = 1'b0;
    case (op)
      3'd0: begin t = {1'b0, a} + {1'b0, b}; r = t[31:0]; c = t[32];
                  v = (a[31] == b[31]) && (r[31] != a[31]); end
      3'd1: begin r = a - b; c = (a < b); v = (a[31] != b[31]) && (r[31] != a[31]); end
      3'd2: r = a ^ b;
      3'd3: r = a | b;
      3'd4: r = a & b;
      3'd5: r = a << b[4:0];
      3'd6: r = a >> b[4:0];
      default: r = $unsigned($signed(a) >>> b[4:0]);
    endcase
    if (l)      model_flg = wd[5:0];
    else if (u) model_flg = {model_flg[5:4], r[31], (r == 32'd0), v, c};
    q_res.push_back(r);
    q_flg.push_back({26'd0, model_flg});
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    upd = 1'b0; load = 1'b0;
  endtask

  // monitor: sample after the edge, inputs change only at negedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_res.size() > 0) begin
        logic [31:0] er, ef;
        string tg;
        er = q_res.pop_front(); ef = q_flg.pop_front(); tg = q_tag.pop_front();
        total++;
        if (result !== er) begin
          bad++; $display("FAIL %s result got %h exp %h", tg, result, er);
        end
        total++;
        if (flags !== ef) begin
          bad++; $display("FAIL %s flags got %h exp %h", tg, flags, ef);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    op_sel = '0; op_a = '0; op_b = '0; upd = 1'b0; load = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (flags !== 32'd0) begin  // R10
      bad++; $display("FAIL R10 reset flags got %h exp %h", flags, 32'd0);
    end
    @(negedge clk) rst_ni = 1'b1;

    drive(3'd0, 32'd1, 32'd2, 1, 0, 0, "R1 add");
    drive(3'd0, 32'hFFFF_FFFF, 32'd1, 1, 0, 0, "R1 R6 add carry zero");
    drive(3'd0, 32'h7FFF_FFFF, 32'd1, 1, 0, 0, "R3 R6 add overflow sign");
    drive(3'd1, 32'd5, 32'd7, 1, 0, 0, "R2 sub borrow");
    drive(3'd1, 32'h8000_0000, 32'd1, 1, 0, 0, "R3 sub overflow");
    drive(3'd2, 32'hF0F0_1234, 32'h0FF0_1234, 1, 0, 0, "R4 R3 xor clears");
    drive(3'd1, 32'd9, 32'd9, 1, 0, 0, "R2 R6 sub equal");
    drive(3'd3, 32'h8000_0001, 32'h0000_0100, 1, 0, 0, "R4 or");
    drive(3'd4, 32'hFF00_FF00, 32'h0FF0_0FF0, 1, 0, 0, "R4 and");
    drive(3'd1, 32'd0, 32'd1, 1, 0, 0, "R2 sub wrap");
    drive(3'd5, 32'd1, 32'd33, 1, 0, 0, "R5 R3 sll amount wraps");
    drive(3'd6, 32'h8000_0000, 32'd31, 1, 0, 0, "R5 srl");
    drive(3'd7, 32'h8000_0000, 32'd4, 1, 0, 0, "R5 sra sign fill");
    drive(3'd7, 32'h4000_0000, 32'd36, 1, 0, 0, "R5 sra positive");
    drive(3'd6, 32'hDEAD_BEEF, 32'd0, 1, 0, 0, "R5 shift zero");
    drive(3'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R7 no update hold");
    drive(3'd1, 32'd3, 32'd4, 0, 0, 0, "R7 no update hold sub");
    drive(3'd0, 32'd0, 32'd0, 0, 1, 32'hFFFF_FFFF, "R9 load all ones");
    drive(3'd0, 32'd1, 32'd1, 1, 0, 0, "R8 ctrl bits kept");
    drive(3'd1, 32'h8000_0000, 32'd1, 1, 0, 0, "R8 R3 ctrl bits kept");
    drive(3'd0, 32'hFFFF_FFFF, 32'd1, 1, 1, 32'h0000_0010, "R9 load beats update");
    drive(3'd2, 32'd5, 32'd5, 1, 0, 0, "R8 R6 xor zero");
    idle();
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (flags !== {26'd0, model_flg}) begin  // R7
      bad++; $display("FAIL R7 idle flags got %h exp %h", flags, {26'd0, model_flg});
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule